// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block caches recent virtual-to-physical page mappings. Every cycle it can take one lookup. The lookup compares the virtual page number against all entries at once. In the same cycle it reports either a hit, with the translated physical address and the entry's read, write, execute and dirty bits, or a miss.

On a miss, an external page-table walker fetches the mapping and presents it on the fill port. The requester then retries the access. The block never writes anything back to the page tables.

Pages are 4 KiB, so the low 12 address bits pass through untranslated. A single-cycle pulse clears every entry, for use when the page-table base changes. A separate request drops the one entry that matches a given virtual page, for use when a page-table or directory entry is edited.

Fills go to an empty slot if one exists. Otherwise they replace the least recently used entry. Successful lookups and fills both count as uses.

A write to a page whose cached dirty bit is clear is reported as a miss. The walker can then mark the page dirty in memory and refill the entry.

Top module: `tlb_fa`

## Requirements
- R1: When lk_valid is high and lk_vaddr[31:12] equals the tag of a valid entry (and R9 does not apply), lk_hit is 1 and lk_miss is 0 in the same cycle. lk_paddr is {stored page number, lk_vaddr[11:0]}, and lk_r, lk_w, lk_x, lk_dirty are that entry's bits.
- R2: When lk_valid is high and no valid entry matches, lk_miss is 1 and lk_hit is 0. When lk_valid is low, both are 0. lk_hit and lk_miss are never high together.
- R3: A fill (fill_valid high) is visible to lookups from the next cycle. If a valid entry already holds fill_vpn, that entry is overwritten, so no page is ever held twice.
- R4: A fill of a page not already present goes to the lowest-numbered invalid entry. If every entry is valid, it replaces the least recently used entry.
- R5: A hit (lk_hit high) and a fill each make their entry the most recently used one. If both happen in one cycle, only the fill's entry is promoted. After reset, the recency order from most to least recent is entry 0 up to entry ENTRIES-1.
- R6: A pulse on base_wr invalidates every entry from the next cycle on. A lookup in the pulse cycle itself still sees the old contents.
- R7: If base_wr and fill_valid are high in the same cycle, the fill is discarded and the recency order is not changed.
- R8: inv_valid with inv_vpn invalidates the valid entry holding that page from the next cycle on. All other entries are unaffected. If a fill arrives in the same cycle, the fill is written after the invalidation.
- R9: A lookup with lk_write high that matches an entry whose dirty bit is 0 reports lk_miss=1, lk_hit=0.
- R10: Lookups never change an entry's contents. A write to a clean page keeps missing until a fill with the dirty bit set arrives.
- R11: After reset, every entry is invalid and every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_write | input | 1 | Lookup is for a store |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Translation found and usable |
| lk_miss | output | 1 | Walk needed; retry after fill |
| lk_paddr | output | 32 | Physical address (valid on hit) |
| lk_r | output | 1 | Read permission of hit entry |
| lk_w | output | 1 | Write permission of hit entry |
| lk_x | output | 1 | Execute permission of hit entry |
| lk_dirty | output | 1 | Dirty bit of hit entry |
| fill_valid | input | 1 | Load a walked entry |
| fill_vpn | input | 20 | Virtual page of the fill |
| fill_ppn | input | 20 | Physical page of the fill |
| fill_perm | input | 4 | Fill bits {r, w, x, dirty} |
| base_wr | input | 1 | Page-table base written: flush all |
| inv_valid | input | 1 | Invalidate one page |
| inv_vpn | input | 20 | Virtual page to invalidate |

## Verification
The bench first fills every slot with distinct pages. Lookups of each page then confirm the translation and offset passthrough, and separate them from stale or shifted mappings.

A set of hits followed by one extra fill shows which entry the recency order picks as the victim. This separates true recency replacement from replacement by slot index or in round-robin order.

Flush, flush colliding with a fill, single-page invalidation, refill of a page already present, and stores to clean versus dirty pages each exercise one corner. These distinguish correct precedence from a fill that survives a flush, duplicate tags, or a write that hits a clean page.

A long random mix over a page space slightly larger than the capacity then keeps the recency order under constant churn.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef struct packed {
    logic r;
    logic w;
    logic x;
    logic d;
  } tlb_perm_t;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20
) (
  input  logic [VPN_W-1:0]               key,
  input  logic [ENTRIES-1:0][VPN_W-1:0]  tags,
  input  logic [ENTRIES-1:0]             valid,
  output logic [ENTRIES-1:0]             hits
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hits[g] = valid[g] && (tags[g] == key);
  end
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               touch_en,
  input  logic [IDX_W-1:0]   touch_idx,
  input  logic [ENTRIES-1:0] valid,
  output logic [IDX_W-1:0]   repl_idx
);
  localparam logic [IDX_W-1:0] AGE_MAX = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0][IDX_W-1:0] age_q, age_d;
  logic [ENTRIES-1:0]            is_old;
  logic [IDX_W-1:0]              old_idx, free_idx;
  logic                          free_any;

  // age 0 is most recent; ages always form a permutation
  always_comb begin
    age_d = age_q;
    if (touch_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDX_W'(i) == touch_idx)
          age_d[i] = '0;
        else if (age_q[i] < age_q[touch_idx])
          age_d[i] = age_q[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
    end else if (touch_en) begin
      age_q <= age_d;
    end
  end

  always_comb begin
    old_idx  = '0;
    free_idx = '0;
    free_any = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      is_old[i] = (age_q[i] == AGE_MAX);
      if (is_old[i]) old_idx = IDX_W'(i);
    end
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        free_idx = IDX_W'(i);
        free_any = 1'b1;
      end
    end
    repl_idx = free_any ? free_idx : old_idx;
  end

  p_single_oldest_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(is_old) == 1);
  p_touch_newest_r5: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> age_q[$past(touch_idx)] == '0);
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int OFF_W   = 12,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int VA_W   = VPN_W + OFF_W,
  localparam int PA_W   = PPN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic             lk_write,
  input  logic [VA_W-1:0]  lk_vaddr,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic [PA_W-1:0]  lk_paddr,
  output logic             lk_r,
  output logic             lk_w,
  output logic             lk_x,
  output logic             lk_dirty,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic [3:0]       fill_perm,
  input  logic             base_wr,
  input  logic             inv_valid,
  input  logic [VPN_W-1:0] inv_vpn
);
  logic [ENTRIES-1:0][VPN_W-1:0] tag_q;
  logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;
  tlb_perm_t [ENTRIES-1:0]       perm_q;
  logic [ENTRIES-1:0]            valid_q, valid_d;

  logic [ENTRIES-1:0] lk_hits, fill_hits, inv_hits;
  logic [IDX_W-1:0]   hit_idx, fill_idx, repl_idx, touch_idx;
  logic [PPN_W-1:0]   hit_ppn;
  tlb_perm_t          hit_perm;
  logic               found, fill_en, touch_en;

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_lk_cam (
    .key(lk_vaddr[VA_W-1:OFF_W]), .tags(tag_q), .valid(valid_q), .hits(lk_hits));
  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_fill_cam (
    .key(fill_vpn), .tags(tag_q), .valid(valid_q), .hits(fill_hits));
  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_inv_cam (
    .key(inv_vpn), .tags(tag_q), .valid(valid_q), .hits(inv_hits));

  // one-hot read mux and index encode
  always_comb begin
    hit_ppn  = '0;
    hit_perm = '0;
    hit_idx  = '0;
    fill_idx = repl_idx;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_hits[i]) begin
        hit_ppn  = hit_ppn | ppn_q[i];
        hit_perm = hit_perm | perm_q[i];
        hit_idx  = IDX_W'(i);
      end
      if (fill_hits[i]) fill_idx = IDX_W'(i);
    end
  end

  assign found    = lk_valid && (|lk_hits);
  assign lk_hit   = found && !(lk_write && !hit_perm.d);
  assign lk_miss  = lk_valid && !lk_hit;
  assign lk_paddr = {hit_ppn, lk_vaddr[OFF_W-1:0]};
  assign lk_r     = hit_perm.r;
  assign lk_w     = hit_perm.w;
  assign lk_x     = hit_perm.x;
  assign lk_dirty = hit_perm.d;

  // flush overrides everything; fill lands after invalidation
  assign fill_en   = fill_valid && !base_wr;
  assign touch_en  = !base_wr && (fill_valid || lk_hit);
  assign touch_idx = fill_valid ? fill_idx : hit_idx;

  always_comb begin
    valid_d = valid_q;
    if (base_wr) begin
      valid_d = '0;
    end else begin
      if (inv_valid) valid_d = valid_q & ~inv_hits;
      if (fill_en)   valid_d[fill_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fill_idx]  <= fill_vpn;
      ppn_q[fill_idx]  <= fill_ppn;
      perm_q[fill_idx] <= tlb_perm_t'(fill_perm);
    end
  end

  tlb_lru #(.ENTRIES(ENTRIES)) u_lru (
    .clk(clk), .rst_n(rst_n), .touch_en(touch_en), .touch_idx(touch_idx),
    .valid(valid_q), .repl_idx(repl_idx));

  p_unique_tag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hits));
  p_hit_miss_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_miss));
  p_write_needs_dirty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_write) |-> lk_dirty);
  p_flush_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
    base_wr |=> valid_q == '0);
  p_inv_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && !fill_valid && !base_wr) |=> (valid_q & $past(inv_hits)) == '0);
endmodule

// File: tb/tb_tlb_fa.sv
module tb_tlb_fa;
  localparam int ENT = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 0, lk_write = 0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_hit, lk_miss, lk_r, lk_w, lk_x, lk_dirty;
  logic [31:0] lk_paddr;
  logic        fill_valid = 0;
  logic [19:0] fill_vpn = '0, fill_ppn = '0;
  logic [3:0]  fill_perm = '0;
  logic        base_wr = 0, inv_valid = 0;
  logic [19:0] inv_vpn = '0;

  int checks = 0, fails = 0;

  bit          m_v[ENT];
  logic [19:0] m_tag[ENT];
  logic [19:0] m_ppn[ENT];
  logic [3:0]  m_perm[ENT];
  int          m_q[$];

  tlb_fa dut (.*);

  always #2 clk = ~clk;

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  function automatic int find(logic [19:0] vpn);
    for (int i = 0; i < ENT; i++) if (m_v[i] && m_tag[i] == vpn) return i;
    return -1;
  endfunction

  task automatic touch(int k);
    for (int j = 0; j < m_q.size(); j++) if (m_q[j] == k) begin m_q.delete(j); break; end
    m_q.push_front(k);
  endtask

  task automatic idle();
    lk_valid = 0; lk_write = 0; fill_valid = 0; base_wr = 0; inv_valid = 0;
  endtask

  // inputs are set at the negedge; compare before posedge, then update model
  task automatic step(string tag);
    int hidx, fidx;
    bit ehit, emiss;
    logic [31:0] epa;
    logic [3:0]  ep;
    #1;
    hidx  = lk_valid ? find(lk_vaddr[31:12]) : -1;
    ehit  = (hidx >= 0) && !(lk_write && !m_perm[hidx][0]);
    emiss = lk_valid && !ehit;
    epa   = (hidx >= 0) ? {m_ppn[hidx], lk_vaddr[11:0]} : '0;
    ep    = (hidx >= 0) ? m_perm[hidx] : '0;
    checks++;
    if (lk_hit !== ehit || lk_miss !== emiss ||
        (ehit && ({lk_paddr, lk_r, lk_w, lk_x, lk_dirty} !== {epa, ep}))) begin
      fails++;
      $display("FAIL %s: hit/miss/pa/perm got %b %b %h %b expected %b %b %h %b",
               tag, lk_hit, lk_miss, lk_paddr, {lk_r, lk_w, lk_x, lk_dirty},
               ehit, emiss, epa, ep);
    end
    @(posedge clk);
    if (base_wr) begin
      for (int i = 0; i < ENT; i++) m_v[i] = 0;
    end else begin
      fidx = -1;
      if (fill_valid) begin
        fidx = find(fill_vpn);
        if (fidx < 0) for (int i = 0; i < ENT; i++) if (!m_v[i]) begin fidx = i; break; end
        if (fidx < 0) fidx = m_q[m_q.size() - 1];
      end
      if (ehit && !fill_valid) touch(hidx);
      if (inv_valid) begin
        int k = find(inv_vpn);
        if (k >= 0) m_v[k] = 0;
      end
      if (fill_valid) begin
        m_v[fidx] = 1; m_tag[fidx] = fill_vpn; m_ppn[fidx] = fill_ppn;
        m_perm[fidx] = fill_perm;
        touch(fidx);
      end
    end
    @(negedge clk);
    idle();
  endtask

  task automatic look(logic [19:0] vpn, bit wr, string tag);
    lk_valid = 1; lk_write = wr; lk_vaddr = {vpn, 12'($urandom)};
    step(tag);
  endtask

  task automatic fill(logic [19:0] vpn, logic [19:0] ppn, logic [3:0] p, string tag);
    fill_valid = 1; fill_vpn = vpn; fill_ppn = ppn; fill_perm = p;
    step(tag);
  endtask

  initial begin
    for (int i = 0; i < ENT; i++) begin m_v[i] = 0; m_q.push_back(i); end
    #5 rst_n = 1'b1;
    @(negedge clk);
    // reset state
    for (int i = 0; i < 4; i++) look(20'(i * 7), 0, "R11");
    step("R2");
    // fill every slot, perm {r,w,x,d}
    for (int i = 0; i < ENT; i++) fill(20'(100 + i), 20'(20'h5000 + i * 3), 4'(i), "R3");
    for (int i = 0; i < ENT; i++) look(20'(100 + i), 0, "R1");
    // stores to clean and dirty pages
    look(20'd100, 1, "R9");
    look(20'd100, 1, "R10");
    look(20'd101, 1, "R9");
    look(20'd100, 0, "R10");
    // refill existing page with dirty set
    fill(20'd100, 20'h0abcd, 4'b1101, "R3");
    look(20'd100, 1, "R3");
    look(20'd100, 0, "R3");
    // recency: hit a few then evict the least recent
    look(20'd101, 0, "R5");
    look(20'd102, 0, "R5");
    fill(20'd900, 20'h11111, 4'b1001, "R4");
    look(20'd900, 0, "R4");
    look(20'd103, 0, "R4");
    look(20'd101, 0, "R5");
    // hit and fill together: only fill promoted
    lk_valid = 1; lk_vaddr = {20'd104, 12'h123};
    fill(20'd901, 20'h22222, 4'b1111, "R5");
    fill(20'd902, 20'h33333, 4'b1111, "R5");
    look(20'd104, 0, "R5");
    look(20'd105, 0, "R5");
    // invalidate one page
    inv_valid = 1; inv_vpn = 20'd110; step("R8");
    look(20'd110, 0, "R8");
    look(20'd111, 0, "R8");
    fill(20'd903, 20'h44444, 4'b1000, "R4");
    look(20'd903, 0, "R4");
    // flush with lookup in the same cycle
    base_wr = 1; lk_valid = 1; lk_vaddr = {20'd111, 12'h0f0}; step("R6");
    look(20'd111, 0, "R6");
    look(20'd901, 0, "R6");
    // flush against fill
    base_wr = 1; fill(20'd777, 20'h77777, 4'b1111, "R7");
    look(20'd777, 0, "R7");
    fill(20'd778, 20'h78787, 4'b1111, "R4");
    look(20'd778, 0, "R4");
    // random churn over a page space larger than capacity
    for (int n = 0; n < 3000; n++) begin
      lk_valid = ($urandom_range(9) < 7);
      lk_write = $urandom_range(1);
      lk_vaddr = {20'($urandom_range(79)), 12'($urandom)};
      fill_valid = ($urandom_range(9) < 3);
      fill_vpn = 20'($urandom_range(79));
      fill_ppn = 20'($urandom);
      fill_perm = 4'($urandom);
      inv_valid = ($urandom_range(19) == 0);
      inv_vpn = 20'($urandom_range(79));
      base_wr = ($urandom_range(199) == 0);
      step("R5");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule